// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word addresses for a multi-register load or store. A request carries a base address, a 16-bit register mask, a mode code, a load/store direction, a writeback request and a caret option. Once the request is accepted, the block issues one beat for each selected register. Each beat carries the register index and its word address and is handed over on a valid/ready handshake. When the last beat has been taken, a one-cycle completion strobe presents the updated base value and the side-band flags.

Callers can name the four basic walking modes directly or use stack-style aliases. The direction of the transfer decides which basic mode an alias resolves to. The block never touches memory or the register file. It only tells downstream logic whether the caret option means "restore saved status" or "use the user-mode register bank".

Top module: `blkxfer_addr_seq`

## Requirements
- R1: For loads, the mode codes resolve as follows: 0 and 4 walk increment-after, 1 and 5 walk increment-before, 2 and 6 walk decrement-after, and 3 and 7 walk decrement-before. Codes 4 to 7 are the aliases full-descending, empty-descending, full-ascending and empty-ascending.
- R2: For stores, the aliases resolve the other way round: 4 (full-descending) walks decrement-before, 5 walks decrement-after, 6 walks increment-before and 7 walks increment-after. Codes 0 to 3 behave as they do for loads.
- R3: Beats come out in ascending register index. Each beat's address is the previous beat's address plus 4, so the lowest index gets the lowest address.
- R4: With N set bits in the mask, the first beat address is base (increment-after), base+4 (increment-before), base-4N+4 (decrement-after) or base-4N (decrement-before), all modulo 2^32.
- R5: At completion, wb_value is base+4N for the increment walks and base-4N for the decrement walks. wb_en is high during the completion cycle exactly when writeback was requested.
- R6: An all-zero mask issues no beats. The completion strobe follows in the cycle after acceptance, with wb_value equal to base.
- R7: A beat that is not accepted keeps its index and address unchanged. Exactly one beat is consumed per cycle in which beat_valid and beat_ready are both high.
- R8: restore_status is high in the completion cycle when the caret option is set on a load whose mask includes bit 15.
- R9: user_bank is high in the completion cycle when the caret option is set on a store, or on a load whose mask lacks bit 15. Neither flag is high when the caret option is clear.
- R10: start_ready is high only while idle. done lasts one cycle, and the block is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request present |
| start_ready | output | 1 | Block idle, request accepted on this edge |
| base_addr | input | 32 | Base address |
| reg_mask | input | 16 | Selected registers, bit i = register i |
| mode | input | 3 | Walk mode code (see R1, R2) |
| is_load | input | 1 | 1 = load, 0 = store |
| writeback | input | 1 | Request base writeback |
| caret | input | 1 | Caret option |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat taken |
| beat_idx | output | 4 | Register index of the beat |
| beat_addr | output | 32 | Word address of the beat |
| done | output | 1 | Completion strobe |
| wb_en | output | 1 | Write wb_value to the base register |
| wb_value | output | 32 | Updated base |
| restore_status | output | 1 | Restore saved status at completion |
| user_bank | output | 1 | Transfer uses user-mode bank |

## Verification
The first beat appears in the cycle after the accepting edge. A non-empty list completes one cycle after its last accepted beat, and an empty list completes one cycle after acceptance. The bench drives and samples on falling edges. It raises beat_ready during a cycle, counts a beat as consumed at the following rising edge, and checks the next beat, or the completion strobe, on the next falling edge. Ready stalls are inserted on a fixed pattern so that held beats are compared again while still unaccepted.

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [NREG-1:0]   reg_mask,
  input  logic [2:0]        mode,
  input  logic              is_load,
  input  logic              writeback,
  input  logic              caret,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [$clog2(NREG)-1:0] beat_idx,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              restore_status,
  output logic              user_bank
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} state_t;
  typedef enum logic [1:0] {W_IA, W_IB, W_DA, W_DB} walk_t;

  state_t            state;
  logic [NREG-1:0]   rem;
  logic [ADDR_W-1:0] cur, wbv_q;
  logic              wb_q, rst_q, usr_q;

  walk_t             walk;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span, first, wbv;
  logic              accept, take, last;

  always_comb begin
    case (mode)
      3'd4:    walk = is_load ? W_IA : W_DB;
      3'd5:    walk = is_load ? W_IB : W_DA;
      3'd6:    walk = is_load ? W_DA : W_IB;
      3'd7:    walk = is_load ? W_DB : W_IA;
      default: walk = walk_t'(mode[1:0]);
    endcase
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(reg_mask[i]);
  end

  always_comb begin
    beat_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (rem[i]) beat_idx = IDX_W'(i);
  end

  assign span   = ADDR_W'(cnt) * STEP;
  assign wbv    = walk[1] ? base_addr - span : base_addr + span;
  assign accept = start_valid && start_ready;
  assign take   = beat_valid && beat_ready;
  assign last   = (rem & (rem - 1'b1)) == '0;

  always_comb begin
    case (walk)
      W_IA:    first = base_addr;
      W_IB:    first = base_addr + STEP;
      W_DA:    first = base_addr - span + STEP;
      default: first = base_addr - span;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rem   <= '0;
      cur   <= '0;
      wbv_q <= '0;
      wb_q  <= 1'b0;
      rst_q <= 1'b0;
      usr_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          rem   <= reg_mask;
          cur   <= first;
          wbv_q <= wbv;
          wb_q  <= writeback;
          rst_q <= caret && is_load && reg_mask[NREG-1];
          usr_q <= caret && !(is_load && reg_mask[NREG-1]);
          state <= (reg_mask == '0) ? S_DONE : S_RUN;
        end
        S_RUN: if (take) begin
          rem <= rem & (rem - 1'b1);
          cur <= cur + STEP;
          if (last) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign start_ready    = state == S_IDLE;
  assign beat_valid     = state == S_RUN;
  assign beat_addr      = cur;
  assign done           = state == S_DONE;
  assign wb_en          = done && wb_q;
  assign wb_value       = wbv_q;
  assign restore_status = done && rst_q;
  assign user_bank      = done && usr_q;

  a_r7_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_idx));
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready |=> !beat_valid ||
      (beat_addr == $past(beat_addr) + STEP && beat_idx > $past(beat_idx)));
  a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && reg_mask == '0 |=> done && !beat_valid);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> start_ready && !done);
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(restore_status && user_bank));
  a_r5_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
endmodule

// File: tb/tb_blkxfer_addr_seq.sv
`timescale 1ns/1ps
module tb_blkxfer_addr_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_valid = 1'b0, start_ready;
  logic [31:0] base_addr = '0;
  logic [15:0] reg_mask = '0;
  logic [2:0]  mode = '0;
  logic        is_load = 1'b0, writeback = 1'b0, caret = 1'b0;
  logic        beat_valid, beat_ready = 1'b0;
  logic [3:0]  beat_idx;
  logic [31:0] beat_addr, wb_value;
  logic        done, wb_en, restore_status, user_bank;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  blkxfer_addr_seq dut (.*);

  always #2.5 clk = ~clk;

  localparam int NV = 13;
  localparam logic [2:0]  V_MODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd6, 3'd7, 3'd7, 3'd3};
  localparam logic        V_LD   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h2000, 32'h3000, 32'h4000, 32'h5000, 32'h5000,
                                           32'h6000, 32'h6000, 32'h7000, 32'h7000, 32'h8000, 32'h8000, 32'h4};
  localparam logic [15:0] V_MASK [NV] = '{16'h0005, 16'h8001, 16'h00F0, 16'hFFFF, 16'h0003, 16'h0003,
                                           16'h0100, 16'h0100, 16'h0011, 16'h0011, 16'h0006, 16'h0006, 16'h0007};
  localparam logic [31:0] V_FIRST[NV] = '{32'h1000, 32'h2004, 32'h2FF4, 32'h3FC0, 32'h5000, 32'h4FF8,
                                           32'h6004, 32'h6000, 32'h6FFC, 32'h7004, 32'h7FF8, 32'h8000, 32'hFFFF_FFF8};
  localparam logic [31:0] V_WB   [NV] = '{32'h1008, 32'h2008, 32'h2FF0, 32'h3FC0, 32'h5008, 32'h4FF8,
                                           32'h6004, 32'h5FFC, 32'h6FF8, 32'h7008, 32'h7FF8, 32'h8008, 32'hFFFF_FFF8};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int c = 0;
    for (int i = 0; i < 16; i++) c += m[i];
    return c;
  endfunction

  function automatic int nth_bit(input logic [15:0] m, input int k);
    int c = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin
      if (c == k) return i;
      c++;
    end
    return -1;
  endfunction

  // reference: returns {first, wb}
  function automatic logic [63:0] model(input logic [2:0] md, input logic ld,
                                        input logic [31:0] b, input logic [15:0] m);
    int w;
    logic [31:0] sp, f, wb;
    case (md)
      3'd4: w = ld ? 0 : 3;
      3'd5: w = ld ? 1 : 2;
      3'd6: w = ld ? 2 : 1;
      3'd7: w = ld ? 3 : 0;
      default: w = int'(md);
    endcase
    sp = 32'(4 * popc(m));
    case (w)
      0: f = b;
      1: f = b + 4;
      2: f = b - sp + 4;
      default: f = b - sp;
    endcase
    wb = (w >= 2) ? b - sp : b + sp;
    return {f, wb};
  endfunction

  task automatic run(input logic [2:0] md, input logic ld, input logic [31:0] b,
                     input logic [15:0] m, input logic wbk, input logic cr,
                     input logic [31:0] ef, input logic [31:0] ew,
                     input logic er, input logic eu, input string tag);
    int k = 0, cyc = 0;
    bit seen = 0;
    @(negedge clk);
    start_valid = 1; mode = md; is_load = ld; base_addr = b; reg_mask = m;
    writeback = wbk; caret = cr;
    @(negedge clk);
    start_valid = 0;
    while (!seen) begin
      if (cyc > 100) begin
        chk(0, {tag, " R7 hang"}, 32'(cyc), 0);
        break;
      end
      if (done) begin
        seen = 1;
        chk(k == popc(m), {tag, " R7 beat count"}, 32'(k), 32'(popc(m)));
        chk(wb_value == ew, {tag, " R5 wb_value"}, wb_value, ew);
        chk(wb_en == wbk, {tag, " R5 wb_en"}, 32'(wb_en), 32'(wbk));
        chk(restore_status == er, {tag, " R8 restore"}, 32'(restore_status), 32'(er));
        chk(user_bank == eu, {tag, " R9 user_bank"}, 32'(user_bank), 32'(eu));
        beat_ready = 0;
      end else if (beat_valid) begin
        chk(32'(beat_idx) == 32'(nth_bit(m, k)), {tag, " R3 beat idx"}, 32'(beat_idx), 32'(nth_bit(m, k)));
        chk(beat_addr == ef + 32'(4 * k), {tag, k == 0 ? " R4 first addr" : " R3 addr step"},
            beat_addr, ef + 32'(4 * k));
        beat_ready = (cyc % 3) != 1;
        if (beat_ready) k++;
      end else begin
        chk(0, {tag, " R10 idle mid-transfer"}, 0, 1);
        break;
      end
      cyc++;
      @(negedge clk);
    end
    beat_ready = 0;
    chk(start_ready == 1, {tag, " R10 ready after done"}, 32'(start_ready), 1);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    chk(start_ready == 1 && beat_valid == 0 && done == 0, "R10 reset state",
        {29'd0, start_ready, beat_valid, done}, 32'h4);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run(V_MODE[i], V_LD[i], V_BASE[i], V_MASK[i], 1'(i % 2), 1'b0,
          V_FIRST[i], V_WB[i], 1'b0, 1'b0, V_LD[i] ? "R1 vec" : "R2 vec");

    for (int i = 0; i < 48; i++) begin
      logic [31:0] b = $urandom & 32'hFFFF_FFFC;
      logic [15:0] m = 16'($urandom);
      r = model(3'(i % 8), 1'((i / 8) % 2), b, m);
      run(3'(i % 8), 1'((i / 8) % 2), b, m, 1'b1, 1'b0, r[63:32], r[31:0], 1'b0, 1'b0, "R1 R2 random");
    end

    // R6: empty list
    @(negedge clk);
    start_valid = 1; reg_mask = 16'h0; base_addr = 32'hABCD_0010; mode = 3'd3; is_load = 1; writeback = 1; caret = 0;
    @(negedge clk);
    start_valid = 0;
    chk(done == 1 && beat_valid == 0, "R6 empty done next cycle", {30'd0, done, beat_valid}, 32'h2);
    chk(wb_value == 32'hABCD_0010, "R6 empty wb_value", wb_value, 32'hABCD_0010);
    @(negedge clk);
    chk(done == 0 && start_ready == 1, "R10 done one cycle", {30'd0, done, start_ready}, 32'h1);

    // R8/R9 caret cases
    run(3'd0, 1'b1, 32'h100, 16'h8002, 1'b0, 1'b1, 32'h100, 32'h108, 1'b1, 1'b0, "R8 load pc caret");
    run(3'd0, 1'b1, 32'h100, 16'h0002, 1'b0, 1'b1, 32'h100, 32'h104, 1'b0, 1'b1, "R9 load nopc caret");
    run(3'd3, 1'b0, 32'h100, 16'h8002, 1'b1, 1'b1, 32'h0F8, 32'h0F8, 1'b0, 1'b1, "R9 store pc caret");
    run(3'd0, 1'b1, 32'h100, 16'h8002, 1'b1, 1'b0, 32'h100, 32'h108, 1'b0, 1'b0, "R9 no caret");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule